// File: doc/BRIEF.md
# Fractional/Integer Multiply-Accumulate Datapath

This block is the arithmetic core of a 16-bit signal-processing datapath. Each cycle it multiplies two 16-bit operands. Each operand is read as two's-complement or as unsigned under its own control, so signed, unsigned and mixed-sign products are all possible. In integer mode the product is the plain mathematical product. In fractional mode the product is doubled so that the binary point stays aligned for Q15 inputs.

The product is sign-extended into a 40-bit field. An operation select then chooses one of four results: the product alone, the product added to a 40-bit accumulator operand, the product subtracted from it, or the negated product. All arithmetic wraps modulo 2^40. The result leaves the block as three fields: an 8-bit guard extension, a 16-bit high word and a 16-bit low word. Two flags go with it. One marks a result that no longer fits in 32 bits. The other marks the clamped fractional product of two most-negative operands.

A parameter selects between a registered output stage and a purely combinational path. In both cases the block accepts new operands every cycle.

Top module: `dsp_mac_core`

## Requirements
- R1: Operand `a_i` is read as two's-complement when `a_signed_i`=1 and as unsigned when `a_signed_i`=0. Operand `b_i` is read the same way under `b_signed_i`. The product is exact for every one of the four combinations, so an unsigned-by-unsigned product is never negative.
- R2: With `frac_i`=0 the product is the exact integer product, sign-extended to 40 bits.
- R3: With `frac_i`=1 the product is twice the exact integer product.
- R4: With `frac_i`=1, both operands signed and both equal to 16'h8000, the product is forced to 40'h00_7FFF_FFFF and `lim_o`=1. In every other case `lim_o`=0.
- R5: `op_i` selects the result: 2'b00 gives the product, 2'b01 gives acc+product, 2'b10 gives acc-product, and 2'b11 gives the negated product. `acc_i` is read as 40-bit two's-complement, and the result wraps modulo 2^40.
- R6: The 40-bit result R is presented as `ext_o`=R[39:32], `hi_o`=R[31:16] and `lo_o`=R[15:0].
- R7: `ovf_o`=1 exactly when bits 39:31 of the result are not all equal.
- R8: With OUT_REG=1, the outputs show the result of the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R9: With OUT_REG=0, the outputs follow the inputs in the same cycle, with no clock involved.
- R10: With `op_i`=2'b00 and both operands signed, `ovf_o` is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_signed_i | input | 1 | 1: `a_i` is two's-complement; 0: unsigned |
| b_signed_i | input | 1 | 1: `b_i` is two's-complement; 0: unsigned |
| frac_i | input | 1 | 1: fractional product (doubled); 0: integer |
| op_i | input | 2 | Result select (see R5) |
| acc_i | input | 40 | Accumulator operand |
| ext_o | output | 8 | Guard extension, result bits 39:32 |
| hi_o | output | 16 | High word, result bits 31:16 |
| lo_o | output | 16 | Low word, result bits 15:0 |
| ovf_o | output | 1 | Result does not fit in 32 bits |
| lim_o | output | 1 | Fractional clamp applied |

## Verification
The bench builds two copies of the block at the default 16-bit operand width and 8 guard bits, and drives both with the same stimulus. One copy has OUT_REG=1 and is compared one cycle after each input change. The other has OUT_REG=0 and is compared in the same cycle. Running both lets a single stimulus stream cover the registered latency and reset clearing as well as the combinational path. The default widths put the 16'h8000 clamp, the unsigned 16'hFFFF squares and the wrap at the 40-bit boundary within reach of directed vectors, which a random stream then follows.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MAC_OP_MPY = 2'b00,
    MAC_OP_ADD = 2'b01,
    MAC_OP_SUB = 2'b10,
    MAC_OP_NEG = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_operand_ext.sv
module mac_operand_ext #(
  parameter int W = 16
) (
  input  logic [W-1:0]        raw_i,
  input  logic                signed_i,
  output logic signed [W:0]   ext_o
);
  // one extra bit lets unsigned and signed values share a signed multiplier
  function automatic logic signed [W:0] widen(input logic [W-1:0] v, input logic s);
    return $signed({s & v[W-1], v});
  endfunction

  assign ext_o = widen(raw_i, signed_i);
endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int OP_W = 16,
  localparam int PX_W = 2*OP_W + 3
) (
  input  logic signed [OP_W:0]  a_x_i,
  input  logic signed [OP_W:0]  b_x_i,
  input  logic                  frac_i,
  output logic signed [PX_W-1:0] prod_o,
  output logic                  lim_o
);
  // most negative signed operand after widening
  localparam logic signed [OP_W:0] MOST_NEG = {2'b11, {(OP_W-1){1'b0}}};
  localparam logic signed [PX_W-1:0] CLAMP =
    {{(PX_W-2*OP_W+1){1'b0}}, {(2*OP_W-1){1'b1}}};

  function automatic logic signed [PX_W-1:0] exact_product(
    input logic signed [OP_W:0] a, input logic signed [OP_W:0] b);
    logic signed [PX_W-1:0] wa, wb;
    wa = a;
    wb = b;
    return wa * wb;
  endfunction

  function automatic logic signed [PX_W-1:0] scale(
    input logic signed [PX_W-1:0] p, input logic f);
    return f ? (p <<< 1) : p;
  endfunction

  logic signed [PX_W-1:0] raw_p;

  assign raw_p  = exact_product(a_x_i, b_x_i);
  assign lim_o  = frac_i && (a_x_i == MOST_NEG) && (b_x_i == MOST_NEG);
  assign prod_o = lim_o ? CLAMP : scale(raw_p, frac_i);
endmodule

// File: rtl/mac_accumulate.sv
module mac_accumulate
  import mac_pkg::*;
#(
  parameter int PX_W  = 35,
  parameter int ACC_W = 40,
  parameter int FIT_W = 32
) (
  input  logic signed [PX_W-1:0] prod_i,
  input  logic [ACC_W-1:0]       acc_i,
  input  mac_op_e                op_i,
  output logic [ACC_W-1:0]       prod_ext_o,
  output logic [ACC_W-1:0]       sum_o,
  output logic                   ovf_o
);
  localparam int TOP_W = ACC_W - FIT_W + 1;

  function automatic logic [ACC_W-1:0] sign_extend(input logic signed [PX_W-1:0] p);
    logic signed [ACC_W-1:0] w;
    w = p;
    return w;
  endfunction

  function automatic logic [ACC_W-1:0] combine(
    input mac_op_e op, input logic [ACC_W-1:0] acc, input logic [ACC_W-1:0] p);
    case (op)
      MAC_OP_ADD: return acc + p;
      MAC_OP_SUB: return acc - p;
      MAC_OP_NEG: return ACC_W'(0) - p;
      default:    return p;
    endcase
  endfunction

  function automatic logic wide(input logic [TOP_W-1:0] t);
    return !((&t) || !(|t));
  endfunction

  assign prod_ext_o = sign_extend(prod_i);
  assign sum_o      = combine(op_i, acc_i, prod_ext_o);
  assign ovf_o      = wide(sum_o[ACC_W-1:FIT_W-1]);
endmodule

// File: rtl/dsp_mac_core.sv
module dsp_mac_core
  import mac_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int PROD_W = 2*OP_W,
  localparam int ACC_W  = PROD_W + GUARD_W,
  localparam int PX_W   = PROD_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OP_W-1:0]    a_i,
  input  logic [OP_W-1:0]    b_i,
  input  logic               a_signed_i,
  input  logic               b_signed_i,
  input  logic               frac_i,
  input  logic [1:0]         op_i,
  input  logic [ACC_W-1:0]   acc_i,
  output logic [GUARD_W-1:0] ext_o,
  output logic [OP_W-1:0]    hi_o,
  output logic [OP_W-1:0]    lo_o,
  output logic               ovf_o,
  output logic               lim_o
);
  logic signed [OP_W:0]   a_x, b_x;
  logic signed [PX_W-1:0] prod_c;
  logic [ACC_W-1:0]       prod_ext_c;
  logic [ACC_W-1:0]       sum_c;
  logic                   ovf_c;
  logic                   lim_c;

  mac_operand_ext #(.W(OP_W)) u_ext_a (.raw_i(a_i), .signed_i(a_signed_i), .ext_o(a_x));
  mac_operand_ext #(.W(OP_W)) u_ext_b (.raw_i(b_i), .signed_i(b_signed_i), .ext_o(b_x));

  mac_multiplier #(.OP_W(OP_W)) u_mul (
    .a_x_i(a_x), .b_x_i(b_x), .frac_i(frac_i), .prod_o(prod_c), .lim_o(lim_c)
  );

  mac_accumulate #(.PX_W(PX_W), .ACC_W(ACC_W), .FIT_W(PROD_W)) u_acc (
    .prod_i(prod_c), .acc_i(acc_i), .op_i(mac_op_e'(op_i)),
    .prod_ext_o(prod_ext_c), .sum_o(sum_c), .ovf_o(ovf_c)
  );

  logic [ACC_W-1:0] res_q;
  logic             ovf_q, lim_q;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= '0;
          ovf_q <= 1'b0;
          lim_q <= 1'b0;
        end else begin
          res_q <= sum_c;
          ovf_q <= ovf_c;
          lim_q <= lim_c;
        end
      end
    end else begin : g_comb
      assign res_q = sum_c;
      assign ovf_q = ovf_c;
      assign lim_q = lim_c;
    end
  endgenerate

  assign ext_o = res_q[ACC_W-1:PROD_W];
  assign hi_o  = res_q[PROD_W-1:OP_W];
  assign lo_o  = res_q[OP_W-1:0];
  assign ovf_o = ovf_q;
  assign lim_o = lim_q;
endmodule

// File: rtl/mac_core_checker.sv
module mac_core_checker #(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int PROD_W = 2*OP_W,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [OP_W-1:0]    a_i,
  input logic [OP_W-1:0]    b_i,
  input logic               a_signed_i,
  input logic               b_signed_i,
  input logic               frac_i,
  input logic [1:0]         op_i,
  input logic [GUARD_W-1:0] ext_o,
  input logic [OP_W-1:0]    hi_o,
  input logic [OP_W-1:0]    lo_o,
  input logic               ovf_o,
  input logic               lim_o,
  input logic [ACC_W-1:0]   prod_ext_c,
  input logic [ACC_W-1:0]   sum_c,
  input logic               ovf_c,
  input logic               lim_c
);
  localparam logic [OP_W-1:0]  MIN_RAW = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] CLAMP   = {{(GUARD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};

  AST_LIMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    lim_c |-> (frac_i && a_signed_i && b_signed_i && a_i == MIN_RAW && b_i == MIN_RAW)); // R4
  AST_LIMIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    lim_c |-> prod_ext_c == CLAMP); // R4
  AST_PRODUCT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b00) |-> sum_c == prod_ext_c); // R5
  AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b00 && !a_signed_i && !b_signed_i) |-> !sum_c[ACC_W-1]); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b00 && a_signed_i && b_signed_i) |-> !ovf_c); // R10

  generate
    if (OUT_REG) begin : g_pipe
      AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({ext_o, hi_o, lo_o} == $past(sum_c) && ovf_o == $past(ovf_c)
                  && lim_o == $past(lim_c))); // R8
    end
  endgenerate
endmodule

bind dsp_mac_core mac_core_checker #(.OP_W(OP_W), .GUARD_W(GUARD_W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .a_signed_i(a_signed_i),
  .b_signed_i(b_signed_i), .frac_i(frac_i), .op_i(op_i), .ext_o(ext_o), .hi_o(hi_o),
  .lo_o(lo_o), .ovf_o(ovf_o), .lim_o(lim_o), .prod_ext_c(prod_ext_c), .sum_c(sum_c),
  .ovf_c(ovf_c), .lim_c(lim_c)
);

// File: tb/sim_dsp_mac_core.sv
`timescale 1ns/1ps
module sim_dsp_mac_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic sa = 1'b0, sb = 1'b0, fr = 1'b0;
  logic [1:0] op = '0;
  logic [39:0] acc = '0;

  logic [7:0]  e0, e1;
  logic [15:0] h0, h1, l0, l1;
  logic v0, v1, m0, m1;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [41:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  dsp_mac_core #(.OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .a_signed_i(sa), .b_signed_i(sb),
    .frac_i(fr), .op_i(op), .acc_i(acc), .ext_o(e0), .hi_o(h0), .lo_o(l0),
    .ovf_o(v0), .lim_o(m0));

  dsp_mac_core #(.OUT_REG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .a_signed_i(sa), .b_signed_i(sb),
    .frac_i(fr), .op_i(op), .acc_i(acc), .ext_o(e1), .hi_o(h1), .lo_o(l1),
    .ovf_o(v1), .lim_o(m1));

  // behavioural reference: {lim, ovf, result}
  function automatic logic [41:0] model(input logic [15:0] ia, input logic [15:0] ib,
      input logic isa, input logic isb, input logic ifr, input logic [1:0] iop,
      input logic [39:0] iacc);
    longint va, vb, p, av, r;
    logic [39:0] res;
    logic lim, ovf;
    va = isa ? longint'($signed(ia)) : longint'({48'd0, ia});
    vb = isb ? longint'($signed(ib)) : longint'({48'd0, ib});
    p = va * vb;
    lim = 1'b0;
    if (ifr) p = p * 2;
    if (ifr && isa && isb && ia == 16'h8000 && ib == 16'h8000) begin
      p = 64'h7FFF_FFFF;
      lim = 1'b1;
    end
    av = longint'($signed(iacc));
    case (iop)
      2'b00: r = p;
      2'b01: r = av + p;
      2'b10: r = av - p;
      default: r = -p;
    endcase
    res = r[39:0];
    ovf = !(res[39:31] == 9'h000 || res[39:31] == 9'h1FF);
    return {lim, ovf, res};
  endfunction

  task automatic compare(input string who, input string tag, input logic [41:0] got,
      input logic [41:0] want);
    n_vec++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s %s: got lim=%0b ovf=%0b res=%h, expected lim=%0b ovf=%0b res=%h",
               tag, who, got[41], got[40], got[39:0], want[41], want[40], want[39:0]);
    end
  endtask

  task automatic drain_one();
    if (exp_q.size() > 0)
      compare("registered/R8", tag_q.pop_front(), {m0, v0, e0, h0, l0}, exp_q.pop_front());
  endtask

  task automatic apply(input logic [15:0] ia, input logic [15:0] ib, input logic isa,
      input logic isb, input logic ifr, input logic [1:0] iop, input logic [39:0] iacc,
      input string tag);
    logic [41:0] want;
    @(negedge clk);
    drain_one();
    a = ia; b = ib; sa = isa; sb = isb; fr = ifr; op = iop; acc = iacc;
    want = model(ia, ib, isa, isb, ifr, iop, iacc);
    #1;
    compare("combinational/R9", tag, {m1, v1, e1, h1, l1}, want);
    exp_q.push_back(want);
    tag_q.push_back(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R8: outputs held at zero under reset with active inputs
    a = 16'h1234; b = 16'h00FF; sa = 1'b1; sb = 1'b1; op = 2'b01; acc = 40'h12_3456_7890;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("reset/R8", "R8", {m0, v0, e0, h0, l0}, 42'd0);
    rst_n = 1'b1;

    apply(16'hFFFD, 16'h0005, 1, 1, 0, 2'b00, '0, "R2");            // -3*5
    apply(16'hFFFF, 16'hFFFF, 0, 0, 0, 2'b00, '0, "R1");            // unsigned square, ovf
    apply(16'hFFFF, 16'hFFFF, 1, 0, 0, 2'b00, '0, "R1");            // mixed -65535
    apply(16'hFFFF, 16'hFFFF, 0, 1, 0, 2'b00, '0, "R1");
    apply(16'h8000, 16'h8000, 1, 1, 0, 2'b00, '0, "R10");           // integer min*min
    apply(16'h7FFF, 16'h8000, 1, 1, 0, 2'b00, '0, "R10");
    apply(16'h4000, 16'h4000, 1, 1, 1, 2'b00, '0, "R3");            // 0.5*0.5
    apply(16'hC000, 16'h4000, 1, 1, 1, 2'b00, '0, "R3");
    apply(16'h8000, 16'h8000, 1, 1, 1, 2'b00, '0, "R4");            // clamp
    apply(16'h8000, 16'h8000, 1, 1, 1, 2'b01, 40'h00_0000_0001, "R4");
    apply(16'h8000, 16'h8000, 0, 1, 1, 2'b00, '0, "R4");            // no clamp
    apply(16'h8000, 16'h8000, 1, 0, 1, 2'b00, '0, "R4");
    apply(16'h0001, 16'h0001, 1, 1, 0, 2'b01, 40'h7F_FFFF_FFFF, "R5"); // wrap
    apply(16'h0001, 16'h0001, 1, 1, 0, 2'b10, 40'h80_0000_0000, "R5");
    apply(16'h0010, 16'h0003, 1, 1, 0, 2'b11, '0, "R5");
    apply(16'h1234, 16'h5678, 0, 0, 0, 2'b10, 40'h00_0000_0000, "R5");
    apply(16'h0001, 16'h0001, 1, 1, 0, 2'b01, 40'h00_7FFF_FFFF, "R7"); // just over 32 bits
    apply(16'h0001, 16'h0001, 1, 1, 0, 2'b10, 40'hFF_8000_0000, "R7");
    apply(16'h0000, 16'h0000, 1, 1, 0, 2'b01, 40'hA5_C3D2_E1F0, "R6"); // field split
    apply(16'h0000, 16'h0000, 1, 1, 0, 2'b01, 40'hFF_8000_0000, "R7");

    for (int i = 0; i < 400; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            2'($urandom), {8'($urandom), 32'($urandom)}, "R5");
    end
    for (int i = 0; i < 40; i++) begin
      apply((i % 2) ? 16'h8000 : 16'($urandom), 16'h8000, 1'($urandom), 1'($urandom),
            1'b1, 2'($urandom), {8'($urandom), 32'($urandom)}, "R4");
    end
    @(negedge clk);
    drain_one();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule